// File: doc/BRIEF.md
# Asynchronous Static RAM Byte-Lane Controller

This block connects a synchronous system bus to one external asynchronous static RAM of 512K words by 16 bits. A requester presents a single-word access: a 19-bit word address, 16 bits of write data, a write flag and a two-bit byte-enable. The controller then runs the memory's active-low strobes through a fixed sequence of clock-counted phases. Those strobes are chip select, output enable, write enable and one select per byte lane. For a read it returns the captured word together with a one-cycle done pulse.

Every phase length is a parameter derived from the clock period and the memory's minimum timings, each rounded up to whole cycles. The shared 16-bit data bus is bidirectional. The controller drives it only during the write-enable pulse, and never in that pulse's first cycle, so the memory has time to release the bus. Every access is followed by one idle cycle before a new request is accepted.

The state machine has seven states. `ST_IDLE` waits for a request and moves to `ST_RD_ACC` for a read or to `ST_WR_SET` for a write. `ST_RD_ACC` holds chip select and output enable low for the read phase and captures the data on its last cycle, then moves to `ST_RD_END`. `ST_WR_SET` holds chip select and the lane selects low for one address setup cycle, then moves to `ST_WR_PULSE`. `ST_WR_PULSE` holds write enable low for the write phase and drives the data from its second cycle onward, then moves to `ST_WR_END`. `ST_RD_END` and `ST_WR_END` release all strobes, pulse done and move to `ST_GAP`. `ST_GAP` is one idle cycle that returns to `ST_IDLE`.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, and whenever `req_ready` is high, all memory strobes are high (inactive), the data bus is not driven and `rsp_done` is low.
- R2: A read keeps `mem_cs_n` and `mem_oe_n` low and `mem_we_n` high for exactly RD_CYC consecutive cycles. `mem_addr` equals the request address and stays stable while chip select is low.
- R3: Byte-enable bit 0 selects the lower lane (data bits 7:0, strobe `mem_lb_n`), and bit 1 selects the upper lane (bits 15:8, strobe `mem_ub_n`). During an access the lane strobes equal the inverted enables. On a read, the bits of a disabled lane return zero in `rsp_rdata`.
- R4: A write holds `mem_we_n` low for exactly WP_CYC consecutive cycles, after one setup cycle in which chip select and the lane selects are already low. `mem_oe_n` stays high for the whole write.
- R5: The controller drives the data bus only while write enable is low and output enable is high, and never in the first cycle of the write pulse.
- R6: A write changes only the lanes whose byte-enable bit is set. The other lane keeps its earlier content.
- R7: `rsp_done` is high for exactly one cycle, in the cycle after the last strobe phase, with all strobes high. `rsp_rdata` then holds the word read.
- R8: After `rsp_done`, `req_ready` stays low for one more cycle. A request presented while `req_ready` is low is never performed.
- R9: RD_CYC is the largest of ceil(T_RC/CLK), ceil(T_AA/CLK) and ceil(T_OE/CLK). WP_CYC is the larger of ceil(T_WP/CLK) and DRV_DLY + ceil(T_DW/CLK), where DRV_DLY = ceil(T_WHZ/CLK). With a 20 ns clock and the default timings, a read's done comes 4 cycles after acceptance and a write's done comes 5 cycles after acceptance.
- R10: An access with byte-enable 00 asserts no lane strobe, changes no stored data, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, held until the next read |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq | inout | 16 | Bidirectional memory data bus |

## Verification
Inputs change on the falling clock edge, and every output is sampled on a falling edge. A request is accepted on the next rising edge. The strobes and address of the first access phase are therefore checked one falling edge later. `rsp_done` and the read word are due RD_CYC+1 falling edges after the request is driven for a read, and WP_CYC+2 falling edges after for a write. The bench computes both values itself from the timing numbers and counts edges to them. It counts the falling edges that see output enable or write enable low between acceptance and done, and compares the totals with RD_CYC and WP_CYC. The idle gap is checked on the done edge and on the edge after it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_END   = 3'd2,
        ST_WR_SET   = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_END   = 3'd5,
        ST_GAP      = 3'd6
    } ctrl_state_e;

    // Whole cycles needed to cover a duration in ns.
    function automatic int cycles_for(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
    assign last  = (cnt_q == limit - 1'b1);

    // R9: a running phase never counts past its limit
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (cnt_q < limit));

endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              drive_on,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] dq_in,
    output logic [LANES-1:0]  lane_drive,
    output logic [DATA_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] byte_q;

        assign lane_drive[g] = drive_on & lane_sel[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (capture) begin
                byte_q <= lane_sel[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = byte_q;
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int LANE_W   = 8,
    parameter int LANES    = 2,
    parameter int CLK_NS   = 20,
    parameter int T_RC_NS  = 45,
    parameter int T_AA_NS  = 45,
    parameter int T_OE_NS  = 30,
    parameter int T_WP_NS  = 45,
    parameter int T_DW_NS  = 25,
    parameter int T_WHZ_NS = 20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [LANES*LANE_W-1:0]   req_wdata,
    input  logic [LANES-1:0]          req_be,
    output logic                      rsp_done,
    output logic [LANES*LANE_W-1:0]   rsp_rdata,
    output logic                      mem_cs_n,
    output logic                      mem_oe_n,
    output logic                      mem_we_n,
    output logic                      mem_ub_n,
    output logic                      mem_lb_n,
    output logic [ADDR_W-1:0]         mem_addr,
    inout  wire  [LANES*LANE_W-1:0]   mem_dq
);

    localparam int DATA_W  = LANES * LANE_W;
    localparam int RD_CYC  = max_of(max_of(cycles_for(T_RC_NS, CLK_NS),
                                           cycles_for(T_AA_NS, CLK_NS)),
                                    cycles_for(T_OE_NS, CLK_NS));
    localparam int DRV_DLY = max_of(cycles_for(T_WHZ_NS, CLK_NS), 1);
    localparam int WP_CYC  = max_of(cycles_for(T_WP_NS, CLK_NS),
                                    DRV_DLY + cycles_for(T_DW_NS, CLK_NS));
    localparam int CNT_W   = $clog2(max_of(RD_CYC, WP_CYC) + 1);

    ctrl_state_e state_q, state_d;

    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;

    logic              timer_clear;
    logic [CNT_W-1:0]  timer_limit;
    logic [CNT_W-1:0]  timer_count;
    logic              timer_last;

    logic              cs_on, oe_on, we_on, lanes_on, drive_on, capture;
    logic [LANES-1:0]  lane_drive;
    logic [DATA_W-1:0] dq_in;

    wire accept = req_valid && (state_q == ST_IDLE);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- request capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            write_q <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = req_write ? ST_WR_SET : ST_RD_ACC;
            ST_RD_ACC:   if (timer_last) state_d = ST_RD_END;
            ST_RD_END:   state_d = ST_GAP;
            ST_WR_SET:   state_d = ST_WR_PULSE;
            ST_WR_PULSE: if (timer_last) state_d = ST_WR_END;
            ST_WR_END:   state_d = ST_GAP;
            ST_GAP:      state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // ---------------- output decode ----------------
    always_comb begin
        cs_on       = 1'b0;
        oe_on       = 1'b0;
        we_on       = 1'b0;
        lanes_on    = 1'b0;
        drive_on    = 1'b0;
        capture     = 1'b0;
        rsp_done    = 1'b0;
        req_ready   = 1'b0;
        timer_clear = 1'b1;
        timer_limit = CNT_W'(RD_CYC);
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_RD_ACC: begin
                cs_on       = 1'b1;
                oe_on       = 1'b1;
                lanes_on    = 1'b1;
                timer_clear = 1'b0;
                capture     = timer_last;
            end
            ST_WR_SET: begin
                cs_on    = 1'b1;
                lanes_on = 1'b1;
            end
            ST_WR_PULSE: begin
                cs_on       = 1'b1;
                we_on       = 1'b1;
                lanes_on    = 1'b1;
                timer_clear = 1'b0;
                timer_limit = CNT_W'(WP_CYC);
                drive_on    = (timer_count >= CNT_W'(DRV_DLY));
            end
            ST_RD_END, ST_WR_END: begin
                rsp_done = 1'b1;
            end
            ST_GAP: begin
            end
            default: begin
            end
        endcase
    end

    assign mem_cs_n = ~cs_on;
    assign mem_oe_n = ~oe_on;
    assign mem_we_n = ~we_on;
    assign mem_lb_n = ~(lanes_on & be_q[0]);
    assign mem_ub_n = ~(lanes_on & be_q[LANES-1]);
    assign mem_addr = addr_q;
    assign dq_in    = mem_dq;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .limit (timer_limit),
        .count (timer_count),
        .last  (timer_last)
    );

    sram_lane_io #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .drive_on   (drive_on),
        .lane_sel   (be_q),
        .dq_in      (dq_in),
        .lane_drive (lane_drive),
        .rdata      (rsp_rdata)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_bus
        assign mem_dq[g*LANE_W +: LANE_W] = lane_drive[g] ? wdata_q[g*LANE_W +: LANE_W]
                                                           : {LANE_W{1'bz}};
    end

    // ---------------- assertions ----------------
    logic [CNT_W:0] we_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run_q <= '0;
        end else if (mem_we_n) begin
            we_run_q <= '0;
        end else if (we_run_q != '1) begin
            we_run_q <= we_run_q + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n
                       && (lane_drive == '0) && !rsp_done));

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    p_lane_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> ({mem_ub_n, mem_lb_n} == ~{be_q[LANES-1], be_q[0]}));

    p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run_q == (CNT_W+1)'(WP_CYC)));

    p_drive_safe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_drive != '0) |-> (mem_oe_n && !mem_we_n && $past(!mem_we_n)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_done_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (mem_cs_n && mem_oe_n && mem_we_n));

    p_gap_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !req_ready);

endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;

    localparam int CLK_NS = 20;

    function automatic int cyc(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected phase lengths from the requirement formulas (R9)
    localparam int EXP_RD  = mx(mx(cyc(45), cyc(45)), cyc(30));
    localparam int EXP_DLY = mx(cyc(20), 1);
    localparam int EXP_WP  = mx(cyc(45), EXP_DLY + cyc(25));
    localparam int RD_LAT  = EXP_RD + 1;
    localparam int WR_LAT  = EXP_WP + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
    logic [18:0] mem_addr;
    wire  [15:0] mem_dq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    int we_lo = 0;
    int oe_lo = 0;
    int clash = 0;

    always #10 clk = ~clk;

    sram_async_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
        .mem_dq(mem_dq)
    );

    // ---------------- memory model ----------------
    logic [15:0] sram [logic [18:0]];
    logic [15:0] shadow [logic [18:0]];
    logic [15:0] model_q = '0;

    function automatic logic [15:0] sram_get(input logic [18:0] a);
        return sram.exists(a) ? sram[a] : 16'h0000;
    endfunction
    function automatic logic [15:0] shadow_get(input logic [18:0] a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    wire rd_on = !mem_cs_n && mem_we_n && !mem_oe_n;
    assign mem_dq[7:0]  = (rd_on && !mem_lb_n) ? model_q[7:0]  : 8'bz;
    assign mem_dq[15:8] = (rd_on && !mem_ub_n) ? model_q[15:8] : 8'bz;

    always @(negedge clk) begin
        logic [15:0] w;
        if (!mem_cs_n && !mem_we_n) begin
            w = sram_get(mem_addr);
            if (!mem_lb_n) w[7:0]  = mem_dq[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq[15:8];
            sram[mem_addr] = w;
        end
        model_q = sram_get(mem_addr);
        if (!mem_we_n) we_lo++;
        if (!mem_oe_n) oe_lo++;
        if (!mem_we_n && !mem_oe_n) clash++;
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic do_op(input logic w, input logic [18:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        int we0, oe0, lat;
        logic [15:0] exp;
        while (!req_ready) @(negedge clk);
        we0 = we_lo;
        oe0 = oe_lo;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        check(mem_addr == a, "R2 address", 32'(mem_addr), 32'(a));
        check({mem_ub_n, mem_lb_n} == ~be, w ? "R6 lane strobes" : "R3 lane strobes",
              32'({mem_ub_n, mem_lb_n}), 32'(~be));
        check(!mem_cs_n && (mem_we_n == 1'b1), "R4/R2 first phase cs low, we high",
              32'({mem_cs_n, mem_we_n}), 32'b01);
        while (!rsp_done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(lat == (w ? WR_LAT : RD_LAT), "R9 done latency", 32'(lat),
              32'(w ? WR_LAT : RD_LAT));
        check(mem_cs_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n,
              "R7 strobes released at done", 32'({mem_cs_n, mem_oe_n, mem_we_n}), 32'h7);
        if (w) begin
            check((we_lo - we0 == EXP_WP) && (oe_lo == oe0), "R4 write pulse width",
                  32'(we_lo - we0), 32'(EXP_WP));
            shadow[a] = (shadow_get(a) & ~lane_mask(be)) | (d & lane_mask(be));
        end else begin
            check((oe_lo - oe0 == EXP_RD) && (we_lo == we0), "R2 read phase width",
                  32'(oe_lo - oe0), 32'(EXP_RD));
            exp = shadow_get(a) & lane_mask(be);
            check(rsp_rdata == exp, (be == 2'b00) ? "R10 read data" : "R3 read data",
                  32'(rsp_rdata), 32'(exp));
        end
        @(negedge clk);
        check(!rsp_done && !req_ready, "R8 gap after done", 32'({rsp_done, req_ready}), 32'h0);
        @(negedge clk);
        check(req_ready, "R8 ready after gap", 32'(req_ready), 32'h1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [18:0] pool [8];
        int d0;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n, "R1 strobes in reset",
              32'({mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}), 32'h1f);
        check(!rsp_done, "R1 done low in reset", 32'(rsp_done), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R1 ready after reset", 32'(req_ready), 32'h1);
        check(mem_cs_n && mem_we_n && mem_oe_n, "R1 idle strobes",
              32'({mem_cs_n, mem_oe_n, mem_we_n}), 32'h7);

        // directed: full word, single lanes, boundary addresses
        do_op(1'b1, 19'h00000, 16'hA55A, 2'b11);
        do_op(1'b1, 19'h7FFFF, 16'h1234, 2'b11);
        do_op(1'b0, 19'h00000, 16'h0000, 2'b11);
        do_op(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
        do_op(1'b1, 19'h00000, 16'hFFC3, 2'b01);   // R6: only lower lane changes
        do_op(1'b0, 19'h00000, 16'h0000, 2'b11);
        do_op(1'b1, 19'h7FFFF, 16'h9EFF, 2'b10);   // R6: only upper lane changes
        do_op(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
        do_op(1'b0, 19'h7FFFF, 16'h0000, 2'b01);   // R3 lower-only read
        do_op(1'b0, 19'h7FFFF, 16'h0000, 2'b10);   // R3 upper-only read
        do_op(1'b1, 19'h00000, 16'h0F0F, 2'b00);   // R10 no lanes written
        do_op(1'b0, 19'h00000, 16'h0000, 2'b11);
        do_op(1'b0, 19'h00000, 16'h0000, 2'b00);   // R10 read returns zero

        // R8: request while busy is never performed
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h00000; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00000;
        req_wdata = 16'hDEAD; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        d0 = 0;
        repeat (12) begin
            @(negedge clk);
            if (rsp_done) d0++;
        end
        check(d0 == 1, "R8 busy request ignored, one done", 32'(d0), 32'h1);
        do_op(1'b0, 19'h00000, 16'h0000, 2'b11);

        // random mix over a small address pool
        foreach (pool[i]) pool[i] = 19'($urandom);
        for (int k = 0; k < 80; k++) begin
            do_op(1'($urandom), pool[$urandom % 8], 16'($urandom), 2'($urandom));
        end
        foreach (pool[i]) do_op(1'b0, pool[i], 16'h0000, 2'b11);

        check(clash == 0, "R4 output and write enable never both low", 32'(clash), 32'h0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule